// File: doc/BRIEF.md
# Fractional NCO Clock Divider Channel

This block is one channel of a numerically controlled clock divider. From its input clock it makes a slower output clock whose average frequency is an exact fraction of the input. A programmed base divisor, counted in half input cycles, fixes the nominal length of each output period. A 32-bit phase accumulator stretches a period by one half cycle whenever its top bit is set, and it advances once per output period by one of two programmed steps. The top bit picks which step: the small positive one while the bit is clear, the wrapping "negative" one while it is set.

Software picks the divisor and the two steps, writes them with the channel disabled, then sets the enable bit. On each enable the accumulator reloads from its seed register and period counting starts again. Half-cycle remainders carry into the next period, so the long-run average is exact. Outputs are a roughly square clock and a one-cycle tick on the first cycle of every output period.

The coarse part of the divisor is stored as the state of an 11-bit Galois shift register. It is not a binary number. The channel counts by stepping that register toward the all-ones state.

Top module: `nco_divider`

## Requirements
- R1: After reset the control, divisor, low-step and high-step words read 0, the seed word reads 0x8000_0000, and `nco_clk` and `nco_tick` are low.
- R2: Word index 0 is control: bit 31 is enable and reads back as written, and all other bits read 0. Index 1 is the divisor, bits 12:0, with upper bits reading 0. Index 2 is the low step, index 3 the high step and index 4 the seed, each 32 bits. Indices 5 to 7 read 0 and ignore writes. Writes land at the clock edge where `reg_we` is high, and reads are combinational.
- R3: Divisor bits 1:0 are the fine count F and bits 12:2 a shift-register code S. One LFSR step maps S to S>>1 when bit 0 is clear, and to (S>>1)^0x500 when it is set. The coarse count C is 2 for S=0. Otherwise C is 3 plus the number of steps from S to 0x7FF. A period spans H = 4C+F+T half cycles, where T is the accumulator top bit during that period.
- R4: Let the enabling write land at edge W, and let Sum_n be the total of H over the first n periods. Tick n is then high during the cycle after edge W+1+ceil(Sum_n/2). Odd halves carry forward, so none are lost.
- R5: On enable the accumulator loads the seed. At the end of each period it adds the low step when its top bit is clear, or the high step when it is set, modulo 2^32. It holds its value at every other time.
- R6: `nco_tick` is high for exactly one cycle per period, and any two ticks are at least four cycles apart.
- R7: `nco_clk` is low throughout the first period after enable. In every later period it is high for the first floor(L/2) cycles, starting with the tick cycle, where L is the length of the period just completed.
- R8: The edge after enable is cleared, `nco_clk` and `nco_tick` go low and stay low. A later enable restarts from the seed, with the same tick timing as a fresh start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word index (byte offset divided by 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| nco_clk | output | 1 | Divided output clock |
| nco_tick | output | 1 | One-cycle pulse at the start of each output period |

## Verification
The assertions assume the bus follows the intended protocol: the divisor, the two steps and the seed are rewritten only while enable is clear. They do not constrain the step values themselves, so the wrapping of the accumulator sum is covered. The stimulus always clears enable before reprogramming. It then sets enable with a separate write, and it holds `reg_we` low during reset. Vectors cover the smallest coarse code (zero) and the all-ones code, as well as the longest code. They also include steps chosen so that the accumulator wraps in both directions.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int unsigned NCO_DW      = 32;
    localparam int unsigned NCO_AW      = 3;
    localparam int unsigned NCO_LFSR_W  = 11;
    localparam int unsigned NCO_FINE_W  = 2;
    localparam int unsigned NCO_TAIL_W  = 5;
    localparam int unsigned NCO_LEN_W   = 13;
    localparam int unsigned NCO_MIN_CRS = 2;
    localparam logic [NCO_LFSR_W-1:0] NCO_TAPS = 11'h500;

    typedef enum logic [NCO_AW-1:0] {
        IDX_CTRL    = 3'd0,
        IDX_DIV     = 3'd1,
        IDX_STEP_LO = 3'd2,
        IDX_STEP_HI = 3'd3,
        IDX_SEED    = 3'd4
    } reg_idx_e;

    typedef struct packed {
        logic                  en;
        logic [NCO_LFSR_W-1:0] coarse;
        logic [NCO_FINE_W-1:0] fine;
        logic [NCO_DW-1:0]     step_lo;
        logic [NCO_DW-1:0]     step_hi;
        logic [NCO_DW-1:0]     seed;
    } nco_cfg_t;
endpackage

// File: rtl/nco_regs.sv
module nco_regs
    import nco_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [NCO_AW-1:0] reg_addr,
    input  logic [NCO_DW-1:0] reg_wdata,
    output logic [NCO_DW-1:0] reg_rdata,
    output nco_cfg_t          cfg
);
    localparam int unsigned DIV_W = NCO_LFSR_W + NCO_FINE_W;
    localparam logic [NCO_DW-1:0] SEED_RST = NCO_DW'(1) << (NCO_DW - 1);

    nco_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we) begin
            case (reg_addr)
                IDX_CTRL:    cfg_d.en = reg_wdata[NCO_DW-1];
                IDX_DIV: begin
                    cfg_d.coarse = reg_wdata[NCO_FINE_W +: NCO_LFSR_W];
                    cfg_d.fine   = reg_wdata[NCO_FINE_W-1:0];
                end
                IDX_STEP_LO: cfg_d.step_lo = reg_wdata;
                IDX_STEP_HI: cfg_d.step_hi = reg_wdata;
                IDX_SEED:    cfg_d.seed    = reg_wdata;
                default:     cfg_d = cfg_q;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            IDX_CTRL:    reg_rdata[NCO_DW-1]  = cfg_q.en;
            IDX_DIV:     reg_rdata[DIV_W-1:0] = {cfg_q.coarse, cfg_q.fine};
            IDX_STEP_LO: reg_rdata = cfg_q.step_lo;
            IDX_STEP_HI: reg_rdata = cfg_q.step_hi;
            IDX_SEED:    reg_rdata = cfg_q.seed;
            default:     reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q         <= '0;
            cfg_q.seed    <= SEED_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             advance,
    input  logic [ACC_W-1:0] step_lo,
    input  logic [ACC_W-1:0] step_hi,
    input  logic [ACC_W-1:0] seed,
    output logic [ACC_W-1:0] acc,
    output logic             top_next
);
    logic [ACC_W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (start) begin
            acc_d = seed;
        end else if (advance) begin
            acc_d = acc_q + (acc_q[ACC_W-1] ? step_hi : step_lo);
        end
        top_next = acc_d[ACC_W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;
endmodule

// File: rtl/nco_period.sv
module nco_period #(
    parameter int unsigned            LW      = 11,
    parameter int unsigned            FW      = 2,
    parameter int unsigned            TW      = 5,
    parameter int unsigned            MIN_CRS = 2,
    parameter logic [LW-1:0]          TAPS    = 11'h500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [LW-1:0] code,
    input  logic [FW-1:0] fine,
    input  logic          top_next,
    output logic          start,
    output logic          period_end
);
    localparam int unsigned   BASE_SHORT = 4 * MIN_CRS;
    localparam int unsigned   BASE_LONG  = 4 * (MIN_CRS + 1);
    localparam logic [LW-1:0] ONES       = '1;
    localparam logic [TW-1:0] TWO        = TW'(2);

    typedef struct packed {
        logic          run;
        logic          in_lfsr;
        logic          half;
        logic [LW-1:0] lfsr;
        logic [TW-1:0] tail;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [LW-1:0] lfsr_step(input logic [LW-1:0] s);
        return s[0] ? ((s >> 1) ^ TAPS) : (s >> 1);
    endfunction

    function automatic st_t load_period(input logic [LW-1:0] c, input logic [FW-1:0] f,
                                        input logic top, input logic owe);
        st_t s;
        logic [TW-1:0] base;
        s         = '0;
        s.run     = 1'b1;
        base      = (c == '0) ? TW'(BASE_SHORT) : TW'(BASE_LONG);
        s.tail    = base + TW'(f) + TW'(top) - TW'(owe);
        s.lfsr    = c;
        s.in_lfsr = (c != '0) && (c != ONES);
        return s;
    endfunction

    always_comb begin
        logic [LW-1:0] nxt;
        nxt        = lfsr_step(st_q.lfsr);
        start      = en && !st_q.run;
        period_end = en && st_q.run && !st_q.in_lfsr && (st_q.tail <= TWO);
        st_d       = st_q;
        if (!en) begin
            st_d.run = 1'b0;
        end else if (start) begin
            st_d = load_period(code, fine, top_next, 1'b0);
        end else if (st_q.in_lfsr) begin
            st_d.half = !st_q.half;
            if (st_q.half) begin
                st_d.lfsr = nxt;
                if (nxt == ONES) st_d.in_lfsr = 1'b0;
            end
        end else if (period_end) begin
            st_d = load_period(code, fine, top_next, st_q.tail == TW'(1));
        end else begin
            st_d.tail = st_q.tail - TWO;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/nco_clkgen.sv
module nco_clkgen #(
    parameter int unsigned LEN_W = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    input  logic period_end,
    output logic nco_clk,
    output logic nco_tick
);
    typedef struct packed {
        logic [LEN_W-1:0] cyc;
        logic [LEN_W-1:0] len;
        logic             hi;
        logic             tick;
    } cg_t;

    cg_t cg_d, cg_q;

    always_comb begin
        cg_d      = cg_q;
        cg_d.tick = 1'b0;
        if (!en) begin
            cg_d.hi = 1'b0;
        end else if (start) begin
            cg_d.cyc = '0;
            cg_d.len = '0;
            cg_d.hi  = 1'b0;
        end else begin
            if (period_end) begin
                cg_d.len  = cg_q.cyc + LEN_W'(1);
                cg_d.cyc  = '0;
                cg_d.tick = 1'b1;
            end else begin
                cg_d.cyc = cg_q.cyc + LEN_W'(1);
            end
            cg_d.hi = cg_d.cyc < (cg_d.len >> 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cg_q <= '0;
        else        cg_q <= cg_d;
    end

    assign nco_clk  = cg_q.hi;
    assign nco_tick = cg_q.tick;
endmodule

// File: rtl/nco_divider.sv
module nco_divider
    import nco_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [NCO_AW-1:0] reg_addr,
    input  logic [NCO_DW-1:0] reg_wdata,
    output logic [NCO_DW-1:0] reg_rdata,
    output logic              nco_clk,
    output logic              nco_tick
);
    nco_cfg_t          cfg;
    logic              en_q;
    logic              run_start;
    logic              period_end;
    logic              top_next;
    logic [NCO_DW-1:0] acc_q;

    nco_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg       (cfg)
    );

    assign en_q = cfg.en;

    nco_phase_acc #(.ACC_W(NCO_DW)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (run_start),
        .advance  (period_end),
        .step_lo  (cfg.step_lo),
        .step_hi  (cfg.step_hi),
        .seed     (cfg.seed),
        .acc      (acc_q),
        .top_next (top_next)
    );

    nco_period #(
        .LW      (NCO_LFSR_W),
        .FW      (NCO_FINE_W),
        .TW      (NCO_TAIL_W),
        .MIN_CRS (NCO_MIN_CRS),
        .TAPS    (NCO_TAPS)
    ) u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .code       (cfg.coarse),
        .fine       (cfg.fine),
        .top_next   (top_next),
        .start      (run_start),
        .period_end (period_end)
    );

    nco_clkgen #(.LEN_W(NCO_LEN_W)) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .start      (run_start),
        .period_end (period_end),
        .nco_clk    (nco_clk),
        .nco_tick   (nco_tick)
    );
endmodule

// File: rtl/nco_divider_chk.sv
module nco_divider_chk
    import nco_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [NCO_AW-1:0] reg_addr,
    input logic [NCO_DW-1:0] reg_wdata,
    input logic [NCO_DW-1:0] reg_rdata,
    input logic              nco_clk,
    input logic              nco_tick,
    input logic              en_q,
    input logic              start,
    input logic              period_end,
    input logic [NCO_DW-1:0] acc_q
);
    p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == IDX_CTRL) |=> (en_q == $past(reg_wdata[NCO_DW-1])));

    p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > IDX_SEED) |-> (reg_rdata == '0));

    p_acc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !period_end) |=> $stable(acc_q));

    p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nco_tick |=> (!nco_tick ##1 !nco_tick ##1 !nco_tick));

    p_tick_with_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nco_tick |-> nco_clk);

    p_first_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !nco_clk);

    p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (!nco_clk && !nco_tick));
endmodule

bind nco_divider nco_divider_chk u_nco_divider_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .nco_clk    (nco_clk),
    .nco_tick   (nco_tick),
    .en_q       (en_q),
    .start      (run_start),
    .period_end (period_end),
    .acc_q      (acc_q)
);

// File: tb/nco_divider_bench.sv
`timescale 1ns/1ps
module nco_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        nco_clk;
    logic        nco_tick;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    nco_divider u_nco_divider (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nco_clk(nco_clk), .nco_tick(nco_tick)
    );

    typedef struct packed {
        logic [11:0] crs;
        logic [1:0]  fin;
        logic [31:0] lo;
        logic [31:0] hi;
        logic [31:0] seed;
        logic [7:0]  n;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{12'd2,    2'd0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 8'd6},
        '{12'd3,    2'd1, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000, 8'd6},
        '{12'd10,   2'd3, 32'h4000_0000, 32'hC000_0000, 32'h8000_0000, 8'd10},
        '{12'd5,    2'd1, 32'h5555_5555, 32'hAAAA_AAAB, 32'h8000_0000, 8'd12},
        '{12'd300,  2'd2, 32'h1000_0000, 32'hF000_0000, 32'h0000_0000, 8'd4},
        '{12'd4,    2'd0, 32'h9000_0000, 32'h9000_0000, 32'h7000_0000, 8'd8},
        '{12'd2049, 2'd3, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 8'd2}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, $sformatf("read idx %0d", a), reg_rdata, exp);
    endtask

    function automatic logic [10:0] code_of(input int c);
        logic [10:0] s;
        if (c == 2) return 11'h0;
        s = 11'h7FF;
        for (int i = 0; i < 2050 - c; i++) s = s[0] ? ((s >> 1) ^ 11'h500) : (s >> 1);
        return s;
    endfunction

    task automatic configure(input vec_t v);
        wr(3'd0, 32'h0);
        wr(3'd1, {19'h0, code_of(int'(v.crs)), v.fin});
        wr(3'd2, v.lo);
        wr(3'd3, v.hi);
        wr(3'd4, v.seed);
    endtask

    // Enable, then check tick times (R3 R4 R5), pulse width (R6), clk duty (R7).
    task automatic measure(input vec_t v, input int nt);
        logic [31:0] acc;
        int sum, tk, tprev, lprev, cyc, highs;
        bit got, prev_tick;
        acc = v.seed; sum = 0; tprev = 0; lprev = 0; cyc = 0; highs = 0; prev_tick = 0;
        wr(3'd0, 32'h8000_0000);
        for (int k = 1; k <= nt; k++) begin
            sum += 4 * int'(v.crs) + int'(v.fin) + int'(acc[31]);
            tk = (sum + 1) / 2;
            acc = acc + (acc[31] ? v.hi : v.lo);
            got = 0;
            while (!got && cyc < tk + 9) begin
                @(posedge clk); #1;
                cyc++;
                if (nco_tick) begin
                    got = 1;
                    check(!prev_tick, "R6", "tick wider than one cycle", 32'(prev_tick), 32'h0);
                end else if (nco_clk) begin
                    highs++;
                end
                prev_tick = nco_tick;
            end
            check(got && cyc == tk + 1, "R3 R4 R5", $sformatf("tick %0d cycle", k),
                  32'(cyc), 32'(tk + 1));
            check(highs == lprev / 2, "R7", $sformatf("clk high cycles before tick %0d", k),
                  32'(highs), 32'(lprev / 2));
            highs = nco_clk ? 1 : 0;
            lprev = tk - tprev;
            tprev = tk;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, 32'h0, "R1");
        rd(3'd1, 32'h0, "R1");
        rd(3'd2, 32'h0, "R1");
        rd(3'd3, 32'h0, "R1");
        rd(3'd4, 32'h8000_0000, "R1");
        check(!nco_clk && !nco_tick, "R1", "outputs after reset", {30'h0, nco_clk, nco_tick}, 32'h0);

        // R2 register map and masking
        wr(3'd0, 32'h7FFF_FFFF);
        rd(3'd0, 32'h0, "R2");
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, 32'h8000_0000, "R2");
        wr(3'd0, 32'h0);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, 32'h0000_1FFF, "R2");
        wr(3'd2, 32'h1234_5678);
        rd(3'd2, 32'h1234_5678, "R2");
        wr(3'd5, 32'hDEAD_BEEF);
        rd(3'd5, 32'h0, "R2");
        rd(3'd7, 32'h0, "R2");
        rd(3'd4, 32'h8000_0000, "R2");
        rd(3'd3, 32'h0, "R2");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            configure(VECS[i]);
            measure(VECS[i], int'(VECS[i].n));
        end

        // R8 disable silences outputs, re-enable restarts from seed
        configure(VECS[3]);
        measure(VECS[3], 3);
        wr(3'd0, 32'h0);
        @(posedge clk); #1;
        for (int i = 0; i < 40; i++) begin
            if (nco_clk || nco_tick)
                check(0, "R8", "output while disabled", {30'h0, nco_clk, nco_tick}, 32'h0);
            @(posedge clk); #1;
        end
        check(!nco_clk && !nco_tick, "R8", "outputs after disable", {30'h0, nco_clk, nco_tick}, 32'h0);
        measure(VECS[3], 4);
        wr(3'd0, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule